// File: doc/BRIEF.md
# Power-On Reset Release Sequencer

The block produces the chip's active-low internal reset. Its inputs are a supply-good comparator level and an external reset pin. It runs on a free-running low-speed on-chip oscillator. The comparator level is synchronized and then debounced by a digital filter. Once the filtered level is good and the pin is released, reset is held for a fixed number of oscillator cycles and then released. Losing the supply, or asserting the pin, pulls reset low again, and the hold count starts over from zero.

Besides the reset output, the block keeps four pieces of state:

- A start-type flag that reads 0 for a cold start. Software may set it to 1 to mark a warm start. The flag survives pin resets, and any power event clears it.
- A two-bit voltage-monitor reset enable, controlled by a hardware configuration bit.
- A clock-divider code for the CPU clock. It returns to divide-by-8 on every reset.
- A clock-enable pulse at the rate that code selects.

The block drives no memory-initialization signal, so RAM contents are untouched by any reset it issues.

Top module: `por_release_seq`

## Requirements
- R1: While `rst_ni` is low, `rst_no` is 0, `warm_o` is 0, `clk_div_o` is 3 and `clk_en_o` is 0.
- R2: The supply-good level passes a 2-flop synchronizer and a filter. The filter accepts a new level only after 4 consecutive samples at that level. A low pulse of 3 or fewer cycles has no effect on `rst_no`.
- R3: `rst_no` rises 32 clock edges after the filtered supply level and the synchronized pin are both good. After a supply rise it is high following edge 38, counted from the first edge at which the raw input is high.
- R4: When the filtered supply level falls, `rst_no` is 0 in that same cycle. For a low supply pulse of L ≥ 4 cycles, `rst_no` is low from edge 6 up to and including edge L+37, and high again after edge L+38.
- R5: A low on `ext_rst_ni` of P cycles passes a 2-flop synchronizer. It holds `rst_no` low from edge 2 through edge P+33 and leaves `warm_o` unchanged.
- R6: A one-cycle pulse on `warm_set_i` while `rst_no` is 1 sets `warm_o` to 1. `warm_o` returns to 0 one edge after the filtered supply level goes low, and at once on `rst_ni`.
- R7: With `cfg_vmon_dis_i` = 0, `vmon_en_o` is 2'b11 and writes through `vmon_we_i` have no effect. With `cfg_vmon_dis_i` = 1, `vmon_en_o` is 2'b00 during reset, and writes while running load `vmon_wdata_i`.
- R8: `clk_div_o` is the code 3 (divide by 2^3 = 8) on every reset release. While running, `div_we_i` loads `div_wdata_i`.
- R9: `clk_en_o` is 0 while `rst_no` is 0. While running it pulses once every 2^`clk_div_o` cycles. With code 3, the first pulse follows the 7th edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Low-speed oscillator clock |
| rst_ni | input | 1 | Asynchronous power-up reset of the block, active low |
| supply_ok_i | input | 1 | Raw supply-good comparator level |
| ext_rst_ni | input | 1 | External reset pin, active low, asynchronous |
| cfg_vmon_dis_i | input | 1 | Configuration bit; 0 forces the voltage-monitor reset on |
| warm_set_i | input | 1 | Software pulse that marks a warm start |
| vmon_we_i | input | 1 | Software write strobe for the monitor enables |
| vmon_wdata_i | input | 2 | Write data for the monitor enables |
| div_we_i | input | 1 | Software write strobe for the divider code |
| div_wdata_i | input | 3 | Write data for the divider code |
| rst_no | output | 1 | Internal reset, active low |
| warm_o | output | 1 | Start type: 0 cold, 1 warm |
| vmon_en_o | output | 2 | Voltage-monitor reset enable bits |
| clk_div_o | output | 3 | CPU clock divider code, divide by 2^code |
| clk_en_o | output | 1 | CPU clock-enable pulse |

## Verification
Edges are counted from the first clock edge at which a changed input is seen.

| Result | Due after |
|---|---|
| Filtered supply level turns | Edge 6 (2 synchronizer + 4 filter edges) |
| `rst_no` falls on supply loss | That same edge 6 |
| `warm_o` cleared by supply loss | Edge 7 |
| `rst_no` falls on pin assertion | Edge 2 |
| `rst_no` rises on pin release | Edge P+34 |
| `rst_no` rises after supply low pulse | Edge L+38 |
| `clk_div_o` back at 3 after pin reset | Edge 3 |
| First `clk_en_o` pulse | 7th edge after release |

The bench drives inputs and samples outputs only at falling edges. Each sweep loop counts edges from the stimulus and compares every output against a closed-form expression of that count, so a result one cycle early or late is reported.

// File: rtl/por_pkg.sv
package por_pkg;
  localparam int DIV_W = 3;
  localparam int PRE_W = (1 << DIV_W) - 1;
  typedef logic [DIV_W-1:0] div_code_t;
  localparam div_code_t DIV_RST = div_code_t'(3);
endpackage

// File: rtl/por_sync.sv
module por_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= {STAGES{RST_VAL}};
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/por_filter.sv
module por_filter #(
  parameter int LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic s_i,
  output logic filt_o
);
  localparam int CW = $clog2(LEN + 1);

  logic [CW-1:0] cnt_q;
  logic          filt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      filt_q <= 1'b0;
    end else if (s_i == filt_q) begin
      cnt_q  <= '0;
    end else if (cnt_q == CW'(LEN - 1)) begin
      cnt_q  <= '0;
      filt_q <= s_i;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign filt_o = filt_q;
endmodule

// File: rtl/por_hold_ctr.sv
module por_hold_ctr #(
  parameter int HOLD = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic good_i,
  output logic rel_o
);
  localparam int CW = $clog2(HOLD + 1);

  logic [CW-1:0] cnt_q;
  logic          rel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rel_q <= 1'b0;
    end else if (!good_i) begin
      cnt_q <= '0;
      rel_q <= 1'b0;
    end else if (!rel_q) begin
      if (cnt_q == CW'(HOLD - 1)) rel_q <= 1'b1;
      else                        cnt_q <= cnt_q + 1'b1;
    end
  end

  assign rel_o = rel_q;
endmodule

// File: rtl/por_clk_sel.sv
module por_clk_sel
  import por_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      run_i,
  input  logic      we_i,
  input  div_code_t wdata_i,
  output div_code_t div_o,
  output logic      en_o
);
  div_code_t        div_q;
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= DIV_RST;
      pre_q <= '0;
    end else if (!run_i) begin
      div_q <= DIV_RST;
      pre_q <= '0;
    end else begin
      if (we_i) div_q <= wdata_i;
      pre_q <= pre_q + 1'b1;
    end
  end

  assign mask  = (PRE_W'(1) << div_q) - PRE_W'(1);
  assign div_o = div_q;
  assign en_o  = run_i && ((pre_q & mask) == mask);
endmodule

// File: rtl/por_release_seq.sv
module por_release_seq
  import por_pkg::*;
#(
  parameter int FILT_LEN = 4,
  parameter int HOLD_CYC = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       supply_ok_i,
  input  logic       ext_rst_ni,
  input  logic       cfg_vmon_dis_i,
  input  logic       warm_set_i,
  input  logic       vmon_we_i,
  input  logic [1:0] vmon_wdata_i,
  input  logic       div_we_i,
  input  logic [2:0] div_wdata_i,
  output logic       rst_no,
  output logic       warm_o,
  output logic [1:0] vmon_en_o,
  output logic [2:0] clk_div_o,
  output logic       clk_en_o
);
  logic sup_s, pin_s, filt_q, good, rel;
  logic warm_q;
  logic [1:0] vmon_q;

  por_sync #(.STAGES(2), .RST_VAL(1'b0)) u_sup_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(supply_ok_i), .q_o(sup_s)
  );

  por_sync #(.STAGES(2), .RST_VAL(1'b0)) u_pin_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ext_rst_ni), .q_o(pin_s)
  );

  por_filter #(.LEN(FILT_LEN)) u_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .s_i(sup_s), .filt_o(filt_q)
  );

  assign good = filt_q & pin_s;

  por_hold_ctr #(.HOLD(HOLD_CYC)) u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .good_i(good), .rel_o(rel)
  );

  // reset drops in the same cycle the qualified level is lost
  assign rst_no = rel & good;

  // start-type flag: power events clear it, pin resets do not
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 warm_q <= 1'b0;
    else if (!filt_q)            warm_q <= 1'b0;
    else if (rst_no && warm_set_i) warm_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  vmon_q <= 2'b11;
    else if (!cfg_vmon_dis_i)     vmon_q <= 2'b11;
    else if (!rst_no)             vmon_q <= 2'b00;
    else if (vmon_we_i)           vmon_q <= vmon_wdata_i;
  end

  por_clk_sel u_clk_sel (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(rst_no),
    .we_i(div_we_i), .wdata_i(div_code_t'(div_wdata_i)),
    .div_o(clk_div_o), .en_o(clk_en_o)
  );

  assign warm_o    = warm_q;
  assign vmon_en_o = vmon_q;
endmodule

// File: rtl/por_release_chk.sv
module por_release_chk #(
  parameter int HOLD_CYC = 32
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cfg_vmon_dis_i,
  input logic       filt_q,
  input logic       pin_s,
  input logic       rst_no,
  input logic       warm_o,
  input logic [1:0] vmon_en_o,
  input logic [2:0] clk_div_o,
  input logic       clk_en_o
);
  localparam int CW = $clog2(HOLD_CYC + 1) + 1;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                run_q <= '0;
    else if (!(filt_q && pin_s)) run_q <= '0;
    else if (run_q != '1)       run_q <= run_q + 1'b1;
  end

  a_r3_hold_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_no) |-> run_q == CW'(HOLD_CYC));

  a_r4_drop_now: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(filt_q) |-> !rst_no);

  a_r6_warm_needs_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(warm_o) |-> $past(rst_no));

  a_r6_warm_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !filt_q |=> !warm_o);

  a_r7_vmon_forced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_vmon_dis_i |=> vmon_en_o == 2'b11);

  a_r8_div_default: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_no) |-> clk_div_o == 3'd3);

  a_r9_no_en_in_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_no |-> !clk_en_o);
endmodule

bind por_release_seq por_release_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_vmon_dis_i(cfg_vmon_dis_i),
  .filt_q(filt_q), .pin_s(pin_s), .rst_no(rst_no), .warm_o(warm_o),
  .vmon_en_o(vmon_en_o), .clk_div_o(clk_div_o), .clk_en_o(clk_en_o)
);

// File: tb/sim_por_release_seq.sv
module sim_por_release_seq;
  localparam int SYNC = 2, FILT = 4, HOLD = 32;
  localparam int REL_SUP = SYNC + FILT + HOLD;

  logic clk_i = 1'b0;
  logic rst_ni, supply_ok_i, ext_rst_ni, cfg_vmon_dis_i, warm_set_i;
  logic vmon_we_i, div_we_i;
  logic [1:0] vmon_wdata_i;
  logic [2:0] div_wdata_i;
  logic rst_no, warm_o, clk_en_o;
  logic [1:0] vmon_en_o;
  logic [2:0] clk_div_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  por_release_seq #(.FILT_LEN(FILT), .HOLD_CYC(HOLD)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .supply_ok_i(supply_ok_i),
    .ext_rst_ni(ext_rst_ni), .cfg_vmon_dis_i(cfg_vmon_dis_i),
    .warm_set_i(warm_set_i), .vmon_we_i(vmon_we_i), .vmon_wdata_i(vmon_wdata_i),
    .div_we_i(div_we_i), .div_wdata_i(div_wdata_i), .rst_no(rst_no),
    .warm_o(warm_o), .vmon_en_o(vmon_en_o), .clk_div_o(clk_div_o),
    .clk_en_o(clk_en_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic set_warm();
    warm_set_i = 1'b1; tick(); warm_set_i = 1'b0;
  endtask

  task automatic write_div(input int c);
    div_wdata_i = 3'(c); div_we_i = 1'b1; tick(); div_we_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    finish_run();
  end

  initial begin
    rst_ni = 1'b0; supply_ok_i = 1'b0; ext_rst_ni = 1'b1; cfg_vmon_dis_i = 1'b0;
    warm_set_i = 1'b0; vmon_we_i = 1'b0; vmon_wdata_i = '0;
    div_we_i = 1'b0; div_wdata_i = '0;
    repeat (3) @(negedge clk_i);
    chk("R1 rst_no", rst_no, 0);
    chk("R1 warm", warm_o, 0);
    chk("R1 div", clk_div_o, 3);
    chk("R1 en", clk_en_o, 0);
    rst_ni = 1'b1;
    for (int k = 0; k < 20; k++) begin
      tick();
      chk("R3 held without supply", rst_no, 0);
    end

    // R3 / R9 / R8: power-up release timing and clock-enable phase
    supply_ok_i = 1'b1;
    for (int k = 1; k <= REL_SUP + 24; k++) begin
      tick();
      chk("R3 release edge", rst_no, int'(k >= REL_SUP));
      chk("R9 en phase", clk_en_o, int'(k >= REL_SUP && ((k - REL_SUP) % 8) == 7));
      if (k >= REL_SUP) chk("R8 div default", clk_div_o, 3);
    end

    // R2 / R4 / R6: supply low pulses of length 1..6
    for (int L = 1; L <= 6; L++) begin
      set_warm();
      chk("R6 warm set", warm_o, 1);
      for (int k = 1; k <= L + REL_SUP + 2; k++) begin
        supply_ok_i = (k <= L) ? 1'b0 : 1'b1;
        tick();
        if (L < FILT) begin
          chk("R2 glitch ignored", rst_no, 1);
          chk("R2 warm kept", warm_o, 1);
        end else begin
          chk("R4 drop and restart", rst_no,
              int'(!(k >= SYNC + FILT && k < L + REL_SUP)));
          chk("R6 warm cleared", warm_o, int'(k < SYNC + FILT + 1));
        end
      end
    end

    // R5 / R8: pin resets of 1..3 cycles
    for (int P = 1; P <= 3; P++) begin
      set_warm();
      write_div(5);
      chk("R8 div write", clk_div_o, 5);
      for (int k = 1; k <= P + SYNC + HOLD + 4; k++) begin
        ext_rst_ni = (k <= P) ? 1'b0 : 1'b1;
        tick();
        chk("R5 pin reset window", rst_no, int'(!(k >= SYNC && k < P + SYNC + HOLD)));
        chk("R5 warm kept", warm_o, 1);
        if (k == SYNC + 1) chk("R8 div reset", clk_div_o, 3);
      end
      chk("R8 div after release", clk_div_o, 3);
    end

    // R9: pulse rate per divider code
    for (int c = 0; c <= 4; c++) begin
      int n;
      write_div(c);
      n = 0;
      for (int k = 0; k < 64; k++) begin
        tick();
        n += int'(clk_en_o);
      end
      chk("R9 en rate", n, 64 >> c);
    end
    write_div(3);

    // R7: monitor enables
    chk("R7 forced on", vmon_en_o, 3);
    vmon_wdata_i = 2'b00; vmon_we_i = 1'b1; tick(); vmon_we_i = 1'b0; tick();
    chk("R7 clear ignored", vmon_en_o, 3);
    cfg_vmon_dis_i = 1'b1;
    for (int k = 1; k <= SYNC + HOLD + 4; k++) begin
      ext_rst_ni = (k <= 1) ? 1'b0 : 1'b1;
      tick();
      if (k == SYNC + 1) chk("R7 off in reset", vmon_en_o, 0);
    end
    chk("R7 running", rst_no, 1);
    vmon_wdata_i = 2'b01; vmon_we_i = 1'b1; tick(); vmon_we_i = 1'b0;
    chk("R7 write 01", vmon_en_o, 1);
    vmon_wdata_i = 2'b10; vmon_we_i = 1'b1; tick(); vmon_we_i = 1'b0;
    chk("R7 write 10", vmon_en_o, 2);
    cfg_vmon_dis_i = 1'b0; tick();
    chk("R7 forced again", vmon_en_o, 3);

    // R1 / R6: block reset while running
    set_warm();
    chk("R6 warm before reset", warm_o, 1);
    rst_ni = 1'b0;
    #1;
    chk("R1 warm after reset", warm_o, 0);
    chk("R1 rst_no after reset", rst_no, 0);
    chk("R1 div after reset", clk_div_o, 3);
    tick();
    finish_run();
  end
endmodule